// File: doc/BRIEF.md
# NAND Asynchronous Strobe Sequencer

This block produces the control strobes for an asynchronous NAND flash bus. It drives write enable, read enable, address latch enable and command latch enable, and it turns the data bus around. The host side is a single request port. The host presents one bus cycle kind (command, address, data write or data read), a write byte and a "wait for ready" flag. The block then plays out that cycle on the flash pins and pulses an acknowledge when the cycle is complete. For a read, the captured byte is available on `rdata` when the acknowledge arrives.

The waveform is not fixed. Three programmable counts, each in whole controller clock periods, shape every cycle:

- **Address setup (AS):** the latch-enable setup and hold around the strobe pulse.
- **Data setup (DS):** the strobe-low width.
- **Data hold (DH):** the strobe-high hold and the data hold after the rising edge.

The counts are sampled when a request is accepted. With a 100 MHz clock, one count step is 10 ns. When the wait flag is set, the block stays busy after the strobes finish. It holds off the acknowledge until the flash ready/busy line, resynchronised through two flops, reads high.

Top module: `nand_strobe_gen`

## Requirements
- R1: While reset is asserted and directly after it, `nand_we_n` and `nand_re_n` are 1, and `nand_ale`, `nand_cle`, `nand_dq_oe` and `ack` are 0.
- R2: A data-write request (`req_kind` = 2) holds `nand_we_n` low for DS cycles and then high for DH cycles, so the whole cycle lasts DS+DH clocks. `nand_dq_oe` is high with `nand_dq_out` equal to the request byte throughout the low phase and for exactly DH cycles after the rising edge. Neither latch enable is raised.
- R3: A data-read request (`req_kind` = 3) holds `nand_re_n` low for DS cycles and then high for DH cycles, a total of DS+DH clocks. `nand_dq_oe` stays low throughout.
- R4: On a read, `rdata` takes the value of `nand_dq_in` sampled at the clock edge that ends the last low cycle of `nand_re_n`. It holds that value when `ack` is seen.
- R5: A command request (`req_kind` = 0) raises `nand_cle` and an address request (`req_kind` = 1) raises `nand_ale`. The latch enable rises AS+1 cycles before `nand_we_n` falls and stays high for AS+1 cycles after `nand_we_n` rises. The write byte stays driven for DH cycles after the rise, and the cycle lasts AS+1+DS+max(DH, AS+1) clocks. AS may be 0.
- R6: A programmed DS or DH of 0 behaves exactly as a value of 1.
- R7: `ack` is a single-cycle pulse in the cycle after a bus cycle ends. A request presented while a cycle is in progress is ignored.
- R8: With `req_wait` set, `ack` is withheld until `nand_rdy` has been high for two clock edges in the resynchroniser. If `nand_rdy` is already high, exactly one extra cycle is added.
- R9: `nand_we_n` and `nand_re_n` are never low together, and `nand_ale` and `nand_cle` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| cfg_addr_setup | input | AS_W | Address setup count AS |
| cfg_data_setup | input | T_W | Data setup count DS (0 acts as 1) |
| cfg_data_hold | input | T_W | Data hold count DH (0 acts as 1) |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_wait | input | 1 | Wait for flash ready after this cycle |
| req_wdata | input | DW | Byte for command, address or write cycles |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | DW | Byte captured by the last read |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_ale | output | 1 | Address latch enable |
| nand_cle | output | 1 | Command latch enable |
| nand_dq_out | output | DW | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | DW | Data bus input value |
| nand_rdy | input | 1 | Flash ready/busy, asynchronous |

## Verification
The assertions cover the relationships that must hold on every clock. These are the exclusivity of the two read/write strobes and of the two latch enables, and that the bus is driven with a steady byte whenever write enable is low. They also check that the bus is never driven while read enable is low, that a latch enable is still high in the cycle after write enable rises, and that `ack` never lasts two cycles. The exact phase lengths cannot be checked cycle by cycle, because each one is a function of the programmed counts. These include the AS+1 setup and hold of the latch enables, the DS and DH strobe widths, the DH data hold, the zero-count substitution, the read capture point, the ready wait and the ignoring of requests while busy. The bench scenarios measure those lengths by counting sampled cycles against values computed from the counts.

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen #(
  parameter int AS_W = 4,
  parameter int T_W  = 4,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AS_W-1:0] cfg_addr_setup,
  input  logic [T_W-1:0]  cfg_data_setup,
  input  logic [T_W-1:0]  cfg_data_hold,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic            req_wait,
  input  logic [DW-1:0]   req_wdata,
  output logic            ack,
  output logic [DW-1:0]   rdata,
  output logic            nand_we_n,
  output logic            nand_re_n,
  output logic            nand_ale,
  output logic            nand_cle,
  output logic [DW-1:0]   nand_dq_out,
  output logic            nand_dq_oe,
  input  logic [DW-1:0]   nand_dq_in,
  input  logic            nand_rdy
);
  localparam int CW = ((AS_W > T_W) ? AS_W : T_W) + 1;
  localparam logic [1:0] K_CMD = 2'd0, K_ADDR = 2'd1, K_READ = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LOW, S_TAIL, S_WAIT} state_t;

  state_t          st;
  logic [CW-1:0]   cnt;
  logic [1:0]      kind;
  logic            wait_f;
  logic [DW-1:0]   wdata;
  logic [AS_W-1:0] as_r;
  logic [T_W-1:0]  ds_r, dh_r;
  logic [1:0]      rdy_sync;

  wire           is_lat   = (kind == K_CMD) || (kind == K_ADDR);
  wire           is_read  = (kind == K_READ);
  wire [CW-1:0]  as1      = CW'(as_r) + CW'(1);
  wire [CW-1:0]  dh_w     = CW'(dh_r);
  wire [CW-1:0]  tail_len = (is_lat && as1 > dh_w) ? as1 : dh_w;
  wire [T_W-1:0] ds_eff   = (cfg_data_setup == '0) ? T_W'(1) : cfg_data_setup;
  wire [T_W-1:0] dh_eff   = (cfg_data_hold == '0) ? T_W'(1) : cfg_data_hold;

  logic [CW-1:0] phase_len;
  always_comb begin
    case (st)
      S_LEAD:  phase_len = as1;
      S_LOW:   phase_len = CW'(ds_r);
      S_TAIL:  phase_len = tail_len;
      default: phase_len = CW'(1);
    endcase
  end
  wire phase_last = (cnt == phase_len - CW'(1));

  wire lat_on = is_lat && ((st == S_LEAD) || (st == S_LOW) || (st == S_TAIL && cnt < as1));

  assign nand_we_n   = !(st == S_LOW && !is_read);
  assign nand_re_n   = !(st == S_LOW && is_read);
  assign nand_ale    = lat_on && (kind == K_ADDR);
  assign nand_cle    = lat_on && (kind == K_CMD);
  assign nand_dq_out = wdata;
  assign nand_dq_oe  = !is_read &&
                       ((st == S_LEAD) || (st == S_LOW) || (st == S_TAIL && cnt < dh_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      kind     <= 2'd2;
      wait_f   <= 1'b0;
      wdata    <= '0;
      as_r     <= '0;
      ds_r     <= T_W'(1);
      dh_r     <= T_W'(1);
      rdy_sync <= '0;
      ack      <= 1'b0;
      rdata    <= '0;
    end else begin
      ack      <= 1'b0;
      rdy_sync <= {rdy_sync[0], nand_rdy};
      case (st)
        S_IDLE: if (req_valid) begin
          kind   <= req_kind;
          wait_f <= req_wait;
          wdata  <= req_wdata;
          as_r   <= cfg_addr_setup;
          ds_r   <= ds_eff;
          dh_r   <= dh_eff;
          cnt    <= '0;
          st     <= (req_kind == K_CMD || req_kind == K_ADDR) ? S_LEAD : S_LOW;
        end
        S_LEAD, S_LOW, S_TAIL: begin
          if (st == S_LOW && is_read && phase_last) rdata <= nand_dq_in;
          if (phase_last) begin
            cnt <= '0;
            if (st == S_LEAD)      st <= S_LOW;
            else if (st == S_LOW)  st <= S_TAIL;
            else if (wait_f)       st <= S_WAIT;
            else begin
              st  <= S_IDLE;
              ack <= 1'b1;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_WAIT: if (rdy_sync[1]) begin
          st  <= S_IDLE;
          ack <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module nand_strobe_gen_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          nand_we_n,
  input logic          nand_re_n,
  input logic          nand_ale,
  input logic          nand_cle,
  input logic [DW-1:0] nand_dq_out,
  input logic          nand_dq_oe
);
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  a_r9_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_ale && nand_cle));
  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  a_r3_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);
  a_r2_drive_while_we_low: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);
  a_r2_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && !$past(nand_we_n)) |-> $stable(nand_dq_out));
  a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nand_we_n) && $past(nand_ale || nand_cle)) |-> (nand_ale || nand_cle));
endmodule

bind nand_strobe_gen nand_strobe_gen_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_ale(nand_ale), .nand_cle(nand_cle), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe)
);

// File: tb/nand_strobe_gen_test.sv
module nand_strobe_gen_test;
  localparam int PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic [3:0] cfg_as = 0, cfg_ds = 1, cfg_dh = 1;
  logic       req_valid = 0, req_wait = 0;
  logic [1:0] req_kind = 0;
  logic [7:0] req_wdata = 0, dq_in = 8'h5A;
  logic       ack, we_n, re_n, ale, cle, dq_oe;
  logic [7:0] rdata, dq_out;
  logic       rdy;

  int checks = 0, fails = 0, cyc = 0, rdy_at = 0;
  int m_len, m_low, m_pre, m_post, m_oe_low, m_oe_post, m_ale, m_cle, m_rcnt;
  bit m_data_ok, m_ack_next;

  always #(PERIOD/2) clk = ~clk;
  always @(negedge clk) cyc++;
  assign rdy = (cyc >= rdy_at);

  nand_strobe_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_addr_setup(cfg_as), .cfg_data_setup(cfg_ds),
    .cfg_data_hold(cfg_dh), .req_valid(req_valid), .req_kind(req_kind), .req_wait(req_wait),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .nand_we_n(we_n), .nand_re_n(re_n),
    .nand_ale(ale), .nand_cle(cle), .nand_dq_out(dq_out), .nand_dq_oe(dq_oe),
    .nand_dq_in(dq_in), .nand_rdy(rdy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] k, input logic [7:0] d, input bit w);
    bit seen;
    @(negedge clk);
    req_valid = 1; req_kind = k; req_wdata = d; req_wait = w;
    @(negedge clk);
    req_valid = 0;
    m_len = 0; m_low = 0; m_pre = 0; m_post = 0; m_oe_low = 0; m_oe_post = 0;
    m_ale = 0; m_cle = 0; m_rcnt = 0; m_data_ok = 1; seen = 0;
    while (!ack && m_len < 300) begin
      if (!we_n || !re_n) begin
        m_low++; seen = 1;
        if (dq_oe) m_oe_low++;
      end else begin
        if (!seen && (ale || cle)) m_pre++;
        if (seen && (ale || cle)) m_post++;
        if (seen && dq_oe) m_oe_post++;
      end
      if (ale) m_ale++;
      if (cle) m_cle++;
      if (dq_oe && dq_out != d) m_data_ok = 0;
      if (!re_n) begin m_rcnt++; dq_in = 8'hA0 + 8'(m_rcnt); end
      else dq_in = 8'h5A;
      m_len++;
      @(negedge clk);
    end
    @(negedge clk);
    m_ack_next = ack;
  endtask

  task automatic t_reset;
    check(we_n && re_n && !ale && !cle && !dq_oe && !ack, "R1 idle levels", {we_n, re_n, ale, cle, dq_oe, ack}, 6'b110000);
  endtask

  task automatic t_write(input int ds, input int dh, input logic [7:0] d);
    cfg_ds = 4'(ds); cfg_dh = 4'(dh);
    run_op(2'd2, d, 0);
    check(m_len == ds + dh, "R2 write length", m_len, ds + dh);
    check(m_low == ds && m_oe_low == ds, "R2 we low width", m_low, ds);
    check(m_oe_post == dh, "R2 data hold", m_oe_post, dh);
    check(m_data_ok && m_ale == 0 && m_cle == 0, "R2 data and no latch", m_ale + m_cle, 0);
    check(!m_ack_next, "R7 ack single", m_ack_next, 0);
  endtask

  task automatic t_read(input int ds, input int dh);
    cfg_ds = 4'(ds); cfg_dh = 4'(dh);
    run_op(2'd3, 8'h00, 0);
    check(m_len == ds + dh, "R3 read length", m_len, ds + dh);
    check(m_low == ds && m_oe_low == 0 && m_oe_post == 0, "R3 re low width, no drive", m_low, ds);
    check(rdata == 8'hA0 + 8'(ds), "R4 read capture", rdata, 8'hA0 + ds);
  endtask

  task automatic t_latch(input logic [1:0] k, input int as, input int ds, input int dh);
    int tl, exp;
    cfg_as = 4'(as); cfg_ds = 4'(ds); cfg_dh = 4'(dh);
    run_op(k, 8'h3C, 0);
    tl = (as + 1 > dh) ? as + 1 : dh;
    exp = as + 1 + ds + tl;
    check(m_len == exp, "R5 latch cycle length", m_len, exp);
    check(m_pre == as + 1, "R5 latch setup", m_pre, as + 1);
    check(m_post == as + 1, "R5 latch hold", m_post, as + 1);
    check(m_oe_post == dh && m_data_ok, "R5 data hold", m_oe_post, dh);
    if (k == 2'd0) check(m_ale == 0 && m_cle > 0, "R5 cmd uses cle", m_ale, 0);
    else check(m_cle == 0 && m_ale > 0, "R5 addr uses ale", m_cle, 0);
  endtask

  task automatic t_zero;
    cfg_ds = 0; cfg_dh = 0;
    run_op(2'd2, 8'h81, 0);
    check(m_len == 2 && m_low == 1 && m_oe_post == 1, "R6 zero write as one", m_len, 2);
    run_op(2'd3, 8'h00, 0);
    check(m_len == 2 && rdata == 8'hA1, "R6 zero read as one", rdata, 8'hA1);
  endtask

  task automatic t_ignore;
    int acks = 0, rlow = 0, wlow = 0;
    cfg_ds = 3; cfg_dh = 3;
    @(negedge clk);
    req_valid = 1; req_kind = 2'd2; req_wdata = 8'h11; req_wait = 0;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 30; i++) begin
      if (i == 2) begin req_valid = 1; req_kind = 2'd3; end
      else req_valid = 0;
      if (ack) acks++;
      if (!re_n) rlow++;
      if (!we_n) wlow++;
      @(negedge clk);
    end
    check(acks == 1, "R7 one ack for one request", acks, 1);
    check(rlow == 0 && wlow == 3, "R7 busy request ignored", rlow, 0);
  endtask

  task automatic t_busy;
    cfg_as = 1; cfg_ds = 2; cfg_dh = 3;
    rdy_at = cyc + 30;
    run_op(2'd0, 8'h70, 1);
    check(m_len >= 27 && m_len <= 34, "R8 ack waits for ready", m_len, 31);
    rdy_at = 0;
    run_op(2'd0, 8'h70, 1);
    check(m_len == 8, "R8 ready already high adds one", m_len, 8);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_write(2, 3, 8'hC5);
    t_write(1, 1, 8'h0F);
    t_read(3, 2);
    t_read(1, 4);
    t_latch(2'd0, 1, 2, 3);
    t_latch(2'd1, 3, 1, 2);
    t_latch(2'd1, 0, 2, 1);
    t_zero;
    t_ignore;
    t_busy;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule